// File: doc/BRIEF.md
# MMU Control and Fault Capture Register File

This block is the register file that sits beside a memory management unit's table walker. It holds the unit's control word, the physical base of the context table, the current context number, and two fault records. The synchronous record captures faults reported by the translation logic. The asynchronous record captures errors from late writes. Software reaches every register through a simple register bus. The bus has a write strobe, a read strobe and an address whose bits [10:8] select one of eight slots, 0x000 through 0x700. Bits [7:0] of the address are ignored.

The translation logic reports a synchronous fault with a one-cycle strobe. The strobe carries:
- the table level at which the walk stopped,
- the access type,
- the fault type,
- external bus error bits,
- an address and a flag saying whether that address is valid,
- the address space of the access.

The block records the fault and raises a one-cycle trap toward the processor. In no-fault mode the fault is still recorded but the trap is withheld, except for accesses in the exempt address space (9 by default). If a second fault lands before software has read the status, the record marks itself as overwritten. Reading the status with the read strobe clears it.

Top module: `mmu_fault_regs`

## Requirements
- R1: After reset, every writable field and both fault records read as zero, the control word reads `{IMPL_ID, VERS_ID, 24'h0}`, `trap` is 0 and `passthrough` is 1.
- R2: A write to slot 0x000 updates SysControl [23:8], PSO [7], NoFault [1] and Enable [0]. Bits [31:28] always read IMPL_ID, bits [27:24] always read VERS_ID, and bits [6:2] read 0. `pso` follows bit 7, and `passthrough` is the inverse of bit 0.
- R3: Slot 0x100 (context table base) keeps bits [31:2] of a write and reads bits [1:0] as 0. Slot 0x200 (context) keeps the low CTX_W bits and reads the rest as 0.
- R4: On the clock edge that samples the fault strobe, slot 0x300 takes the value {14'b0, ebe[17:10], level[9:8], access[7:5], ftype[4:2], addr_valid[1], ow[0]}.
- R5: Slot 0x400 loads the fault address only from a strobe whose address-valid flag is 1. Otherwise it holds.
- R6: The OW bit becomes 1 when a fault is captured while an earlier captured fault is still unread. OW stays 1 through later faults until a status read.
- R7: A read strobe at slot 0x300 clears the whole status word on that edge. If a fault is captured on the same edge, the new fault is stored with OW 0.
- R8: Writes to slots 0x300, 0x400, 0x500 and 0x600 change nothing.
- R9: `trap` is high for exactly the cycle after a fault strobe when NoFault was 0 before that edge. When NoFault is 1, it is high only if the fault's address space equals EXEMPT_ASI.
- R10: An asynchronous error strobe sets slot 0x500 to {UCE[12], BTO[11], BERR[10], high address bits[7:4], AFO[0]=1} and loads slot 0x600. A read strobe at 0x500 clears slot 0x500 only.
- R11: Slot 0x700 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe (clear-on-read side effect) |
| reg_addr | input | ADDR_W (11) | Register byte offset, slot in [10:8] |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed slot, combinational |
| fault_valid | input | 1 | Synchronous fault strobe |
| fault_level | input | 2 | Table level where the walk stopped |
| fault_access | input | 3 | Access type code |
| fault_type | input | 3 | Fault type code |
| fault_ebe | input | 8 | External bus error bits |
| fault_addr_valid | input | 1 | Fault address is meaningful |
| fault_addr | input | 32 | Faulting virtual address |
| fault_asi | input | ASI_W (8) | Address space of the faulting access |
| async_valid | input | 1 | Asynchronous error strobe |
| async_uce | input | 1 | Uncorrectable error flag |
| async_bto | input | 1 | Bus timeout flag |
| async_berr | input | 1 | Generic bus error flag |
| async_addr_hi | input | 4 | Physical address bits above bit 31 |
| async_addr | input | 32 | Low 32 bits of the erroring physical address |
| trap | output | 1 | One-cycle fault trap request |
| passthrough | output | 1 | Translation disabled, addresses used as physical |
| pso | output | 1 | Partial store order selected |

## Verification
The assertions assume that each fault and async strobe is a single-cycle event with stable fields, and that the read strobe is decoded from the same address the bus presents. They also assume the address space input is only meaningful while the fault strobe is high. The bench drives every input at the falling edge and holds it for a full cycle. It raises strobes only for one cycle at a time, except where a status read is deliberately placed on the same edge as a fault. It keeps all unused inputs at zero, so every assertion precondition is met only by intended stimulus.

// File: rtl/mmu_fault_pkg.sv
// Shared types and constants for the MMU control and fault register file.
package mmu_fault_pkg;

    localparam int DATA_W  = 32;
    localparam int N_SLOTS = 8;
    localparam int SLOT_W  = $clog2(N_SLOTS);

    // Register slots, selected by address bits [10:8].
    typedef enum logic [SLOT_W-1:0] {
        SLOT_CTRL = 3'd0,
        SLOT_CTP  = 3'd1,
        SLOT_CTX  = 3'd2,
        SLOT_FSR  = 3'd3,
        SLOT_FAR  = 3'd4,
        SLOT_AFSR = 3'd5,
        SLOT_AFAR = 3'd6,
        SLOT_NONE = 3'd7
    } slot_e;

    // One captured synchronous fault.
    typedef struct packed {
        logic [7:0] ebe;
        logic [1:0] level;
        logic [2:0] access;
        logic [2:0] ftype;
        logic       fav;
        logic       ow;
    } fault_rec_t;

    // One captured asynchronous error.
    typedef struct packed {
        logic       uce;
        logic       bto;
        logic       berr;
        logic [3:0] hi;
        logic       afo;
    } async_rec_t;

    function automatic logic [DATA_W-1:0] pack_fsr(input fault_rec_t r);
        return {14'd0, r.ebe, r.level, r.access, r.ftype, r.fav, r.ow};
    endfunction

    function automatic logic [DATA_W-1:0] pack_afsr(input async_rec_t r);
        return {19'd0, r.uce, r.bto, r.berr, 2'd0, r.hi, 3'd0, r.afo};
    endfunction

endpackage

// File: rtl/mmu_reg_decode.sv
// Slot decoder for the register bus.
// Turns the address and strobes into one-hot write and read selects.
// Assumes the slot index sits in bits [SLOT_LSB +: SLOT_W] and that the
// bits below SLOT_LSB are don't-care.
module mmu_reg_decode #(
    parameter int ADDR_W   = 11,
    parameter int SLOT_LSB = 8
) (
    input  logic                                 wr_en,
    input  logic                                 rd_en,
    input  logic [ADDR_W-1:0]                    addr,
    output logic [mmu_fault_pkg::SLOT_W-1:0]     slot,
    output logic [mmu_fault_pkg::N_SLOTS-1:0]    wr_sel,
    output logic [mmu_fault_pkg::N_SLOTS-1:0]    rd_sel
);
    import mmu_fault_pkg::*;

    assign slot = addr[SLOT_LSB +: SLOT_W];

    // One select line per slot, qualified by its strobe.
    for (genvar i = 0; i < N_SLOTS; i++) begin : g_sel
        assign wr_sel[i] = wr_en && (slot == SLOT_W'(i));
        assign rd_sel[i] = rd_en && (slot == SLOT_W'(i));
    end

endmodule

// File: rtl/mmu_ctrl_regs.sv
// Control word, context table base and context number.
// IMPL and VERS are fixed by parameters.
// Reserved bits are not stored and read as zero.
module mmu_ctrl_regs #(
    parameter logic [3:0] IMPL_ID = 4'h1,
    parameter logic [3:0] VERS_ID = 4'h2,
    parameter int         CTX_W   = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_ctrl,
    input  logic        wr_ctp,
    input  logic        wr_ctx,
    input  logic [31:0] wdata,
    output logic [31:0] ctrl_word,
    output logic [31:0] ctp_word,
    output logic [31:0] ctx_word,
    output logic        enable,
    output logic        nofault,
    output logic        pso
);
    logic [15:0]      sysctl_q;
    logic             pso_q;
    logic             nofault_q;
    logic             enable_q;
    logic [31:2]      ctp_q;
    logic [CTX_W-1:0] ctx_q;

    // Control word fields: written as a group from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sysctl_q  <= '0;
            pso_q     <= 1'b0;
            nofault_q <= 1'b0;
            enable_q  <= 1'b0;
        end else if (wr_ctrl) begin
            sysctl_q  <= wdata[23:8];
            pso_q     <= wdata[7];
            nofault_q <= wdata[1];
            enable_q  <= wdata[0];
        end
    end

    // Context table base: word aligned, low two bits dropped.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctp_q <= '0;
        else if (wr_ctp) ctp_q <= wdata[31:2];
    end

    // Context number: only CTX_W bits are kept.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctx_q <= '0;
        else if (wr_ctx) ctx_q <= wdata[CTX_W-1:0];
    end

    assign ctrl_word = {IMPL_ID, VERS_ID, sysctl_q, pso_q, 5'd0, nofault_q, enable_q};
    assign ctp_word  = {ctp_q, 2'b00};
    assign ctx_word  = 32'(ctx_q);
    assign enable    = enable_q;
    assign nofault   = nofault_q;
    assign pso       = pso_q;

endmodule

// File: rtl/mmu_sync_fault.sv
// Synchronous fault record, fault address and trap generation.
// Assumes fault_valid is a one-cycle strobe with all fields valid alongside.
// A status read clears the record. A fault on the same edge as the read
// wins and starts a fresh record with OW clear.
module mmu_sync_fault #(
    parameter int         ASI_W      = 8,
    parameter logic [7:0] EXEMPT_ASI = 8'd9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fault_valid,
    input  logic [1:0]       fault_level,
    input  logic [2:0]       fault_access,
    input  logic [2:0]       fault_type,
    input  logic [7:0]       fault_ebe,
    input  logic             fault_addr_valid,
    input  logic [31:0]      fault_addr,
    input  logic [ASI_W-1:0] fault_asi,
    input  logic             rd_clr,
    input  logic             nofault,
    output logic [31:0]      fsr_word,
    output logic [31:0]      far_word,
    output logic             trap
);
    import mmu_fault_pkg::*;

    fault_rec_t  rec_q;
    logic        pending_q;
    logic [31:0] far_q;
    logic        trap_q;
    logic        exempt;

    assign exempt = (fault_asi == ASI_W'(EXEMPT_ASI));

    // Status record: capture, overwrite flag and clear-on-read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_q     <= '0;
            pending_q <= 1'b0;
        end else if (fault_valid) begin
            rec_q.ebe    <= fault_ebe;
            rec_q.level  <= fault_level;
            rec_q.access <= fault_access;
            rec_q.ftype  <= fault_type;
            rec_q.fav    <= fault_addr_valid;
            rec_q.ow     <= (rec_q.ow | pending_q) & ~rd_clr;
            pending_q    <= 1'b1;
        end else if (rd_clr) begin
            rec_q     <= '0;
            pending_q <= 1'b0;
        end
    end

    // Fault address: loaded only when the walker vouches for it.
    always_ff @(posedge clk) begin
        if (!rst_n)                             far_q <= '0;
        else if (fault_valid && fault_addr_valid) far_q <= fault_addr;
    end

    // Trap pulse: withheld in no-fault mode unless in the exempt space.
    always_ff @(posedge clk) begin
        if (!rst_n) trap_q <= 1'b0;
        else        trap_q <= fault_valid && (!nofault || exempt);
    end

    assign fsr_word = pack_fsr(rec_q);
    assign far_word = far_q;
    assign trap     = trap_q;

endmodule

// File: rtl/mmu_async_fault.sv
// Asynchronous error record and its physical address.
// Assumes async_valid is a one-cycle strobe.
// A new error replaces the previous one. A read of the status clears only
// the status; a new error on the same edge wins.
module mmu_async_fault (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        async_valid,
    input  logic        async_uce,
    input  logic        async_bto,
    input  logic        async_berr,
    input  logic [3:0]  async_addr_hi,
    input  logic [31:0] async_addr,
    input  logic        rd_clr,
    output logic [31:0] afsr_word,
    output logic [31:0] afar_word
);
    import mmu_fault_pkg::*;

    async_rec_t  arec_q;
    logic [31:0] afar_q;

    // Status: set by an error, cleared by a status read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arec_q <= '0;
        end else if (async_valid) begin
            arec_q.uce  <= async_uce;
            arec_q.bto  <= async_bto;
            arec_q.berr <= async_berr;
            arec_q.hi   <= async_addr_hi;
            arec_q.afo  <= 1'b1;
        end else if (rd_clr) begin
            arec_q <= '0;
        end
    end

    // Address: follows every error, untouched by reads.
    always_ff @(posedge clk) begin
        if (!rst_n)           afar_q <= '0;
        else if (async_valid) afar_q <= async_addr;
    end

    assign afsr_word = pack_afsr(arec_q);
    assign afar_word = afar_q;

endmodule

// File: rtl/mmu_fault_regs.sv
// Top of the MMU control and fault capture register file.
// It ties the slot decoder, the control registers and the two fault
// records together and muxes read data.
// Assumes a single-cycle register bus with combinational read data and
// side effects taken on the clock edge.
module mmu_fault_regs #(
    parameter int         ADDR_W     = 11,
    parameter int         ASI_W      = 8,
    parameter int         CTX_W      = 8,
    parameter logic [3:0] IMPL_ID    = 4'h1,
    parameter logic [3:0] VERS_ID    = 4'h2,
    parameter logic [7:0] EXEMPT_ASI = 8'd9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              fault_valid,
    input  logic [1:0]        fault_level,
    input  logic [2:0]        fault_access,
    input  logic [2:0]        fault_type,
    input  logic [7:0]        fault_ebe,
    input  logic              fault_addr_valid,
    input  logic [31:0]       fault_addr,
    input  logic [ASI_W-1:0]  fault_asi,
    input  logic              async_valid,
    input  logic              async_uce,
    input  logic              async_bto,
    input  logic              async_berr,
    input  logic [3:0]        async_addr_hi,
    input  logic [31:0]       async_addr,
    output logic              trap,
    output logic              passthrough,
    output logic              pso
);
    import mmu_fault_pkg::*;

    logic [SLOT_W-1:0]  slot;
    logic [N_SLOTS-1:0] wr_sel;
    logic [N_SLOTS-1:0] rd_sel;
    logic [31:0] ctrl_word, ctp_word, ctx_word;
    logic [31:0] fsr_word, far_word, afsr_word, afar_word;
    logic        ctrl_enable;
    logic        ctrl_nofault;

    mmu_reg_decode #(.ADDR_W(ADDR_W), .SLOT_LSB(8)) u_dec (
        .wr_en  (reg_wr_en),
        .rd_en  (reg_rd_en),
        .addr   (reg_addr),
        .slot   (slot),
        .wr_sel (wr_sel),
        .rd_sel (rd_sel)
    );

    mmu_ctrl_regs #(.IMPL_ID(IMPL_ID), .VERS_ID(VERS_ID), .CTX_W(CTX_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctrl   (wr_sel[SLOT_CTRL]),
        .wr_ctp    (wr_sel[SLOT_CTP]),
        .wr_ctx    (wr_sel[SLOT_CTX]),
        .wdata     (reg_wdata),
        .ctrl_word (ctrl_word),
        .ctp_word  (ctp_word),
        .ctx_word  (ctx_word),
        .enable    (ctrl_enable),
        .nofault   (ctrl_nofault),
        .pso       (pso)
    );

    mmu_sync_fault #(.ASI_W(ASI_W), .EXEMPT_ASI(EXEMPT_ASI)) u_sync (
        .clk              (clk),
        .rst_n            (rst_n),
        .fault_valid      (fault_valid),
        .fault_level      (fault_level),
        .fault_access     (fault_access),
        .fault_type       (fault_type),
        .fault_ebe        (fault_ebe),
        .fault_addr_valid (fault_addr_valid),
        .fault_addr       (fault_addr),
        .fault_asi        (fault_asi),
        .rd_clr           (rd_sel[SLOT_FSR]),
        .nofault          (ctrl_nofault),
        .fsr_word         (fsr_word),
        .far_word         (far_word),
        .trap             (trap)
    );

    mmu_async_fault u_async (
        .clk           (clk),
        .rst_n         (rst_n),
        .async_valid   (async_valid),
        .async_uce     (async_uce),
        .async_bto     (async_bto),
        .async_berr    (async_berr),
        .async_addr_hi (async_addr_hi),
        .async_addr    (async_addr),
        .rd_clr        (rd_sel[SLOT_AFSR]),
        .afsr_word     (afsr_word),
        .afar_word     (afar_word)
    );

    // Read mux: unmapped slot returns zero.
    always_comb begin
        case (slot_e'(slot))
            SLOT_CTRL: reg_rdata = ctrl_word;
            SLOT_CTP:  reg_rdata = ctp_word;
            SLOT_CTX:  reg_rdata = ctx_word;
            SLOT_FSR:  reg_rdata = fsr_word;
            SLOT_FAR:  reg_rdata = far_word;
            SLOT_AFSR: reg_rdata = afsr_word;
            SLOT_AFAR: reg_rdata = afar_word;
            default:   reg_rdata = '0;
        endcase
    end

    assign passthrough = ~ctrl_enable;

endmodule

// File: rtl/mmu_fault_regs_chk.sv
// Assertion checker for mmu_fault_regs, attached through bind.
// Assumes single-cycle strobes and slot decode on address bits [10:8].
module mmu_fault_regs_chk #(
    parameter int         ADDR_W     = 11,
    parameter int         ASI_W      = 8,
    parameter logic [7:0] EXEMPT_ASI = 8'd9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_rd_en,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              fault_valid,
    input logic              fault_addr_valid,
    input logic [ASI_W-1:0]  fault_asi,
    input logic              ctrl_nofault,
    input logic [31:0]       fsr_word,
    input logic [31:0]       far_word,
    input logic              trap
);
    logic rd_fsr;
    assign rd_fsr = reg_rd_en && (reg_addr[10:8] == 3'd3);

    // R4: the address-valid bit of the status follows the captured strobe
    a_r4_fav_follows: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |=> (fsr_word[1] == $past(fault_addr_valid)));

    // R5: the fault address holds unless a vouched address arrives
    a_r5_far_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(fault_valid && fault_addr_valid) |=> $stable(far_word));

    // R6: OW is sticky until a status read
    a_r6_ow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (fsr_word[0] && !rd_fsr) |=> fsr_word[0]);

    // R7: a read with no competing fault empties the status
    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fsr && !fault_valid) |=> (fsr_word == 32'd0));

    // R9: a trap always follows a fault strobe
    a_r9_trap_cause: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> $past(fault_valid));

    // R9: no-fault mode suppresses traps outside the exempt space
    a_r9_nofault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_valid && ctrl_nofault && (fault_asi != ASI_W'(EXEMPT_ASI))) |=> !trap);

endmodule

bind mmu_fault_regs mmu_fault_regs_chk #(
    .ADDR_W(ADDR_W), .ASI_W(ASI_W), .EXEMPT_ASI(EXEMPT_ASI)
) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .reg_rd_en        (reg_rd_en),
    .reg_addr         (reg_addr),
    .fault_valid      (fault_valid),
    .fault_addr_valid (fault_addr_valid),
    .fault_asi        (fault_asi),
    .ctrl_nofault     (ctrl_nofault),
    .fsr_word         (fsr_word),
    .far_word         (far_word),
    .trap             (trap)
);

// File: tb/mmu_fault_regs_bench.sv
`timescale 1ns/1ps
module mmu_fault_regs_bench;

    localparam logic [3:0] IMPL = 4'h1;
    localparam logic [3:0] VERS = 4'h2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 0, reg_rd_en = 0;
    logic [10:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        fault_valid = 0, fault_addr_valid = 0;
    logic [1:0]  fault_level = '0;
    logic [2:0]  fault_access = '0, fault_type = '0;
    logic [7:0]  fault_ebe = '0, fault_asi = '0;
    logic [31:0] fault_addr = '0;
    logic        async_valid = 0, async_uce = 0, async_bto = 0, async_berr = 0;
    logic [3:0]  async_addr_hi = '0;
    logic [31:0] async_addr = '0;
    logic        trap, passthrough, pso;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit started = 0;

    always #10 clk = ~clk;

    mmu_fault_regs u_mmu_fault_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .fault_valid(fault_valid), .fault_level(fault_level),
        .fault_access(fault_access), .fault_type(fault_type),
        .fault_ebe(fault_ebe), .fault_addr_valid(fault_addr_valid),
        .fault_addr(fault_addr), .fault_asi(fault_asi),
        .async_valid(async_valid), .async_uce(async_uce), .async_bto(async_bto),
        .async_berr(async_berr), .async_addr_hi(async_addr_hi),
        .async_addr(async_addr),
        .trap(trap), .passthrough(passthrough), .pso(pso)
    );

    // Behavioural reference state
    logic [15:0] m_sys; logic m_pso, m_nf, m_en;
    logic [31:0] m_ctp; logic [7:0] m_ctx;
    logic [7:0] m_ebe; logic [1:0] m_lvl; logic [2:0] m_at, m_ft;
    logic m_fav, m_ow, m_pend, m_trap;
    logic [31:0] m_far;
    logic m_uce, m_bto, m_berr, m_afo; logic [3:0] m_hi;
    logic [31:0] m_afar;

    function automatic logic [31:0] fsr_val(logic [7:0] e, logic [1:0] l, logic [2:0] a,
                                            logic [2:0] t, logic v, logic o);
        return (32'(e) << 10) | (32'(l) << 8) | (32'(a) << 5) | (32'(t) << 2)
             | (32'(v) << 1) | 32'(o);
    endfunction

    function automatic logic [31:0] m_read(logic [2:0] s);
        case (s)
            3'd0: return {IMPL, VERS, m_sys, m_pso, 5'd0, m_nf, m_en};
            3'd1: return m_ctp;
            3'd2: return 32'(m_ctx);
            3'd3: return fsr_val(m_ebe, m_lvl, m_at, m_ft, m_fav, m_ow);
            3'd4: return m_far;
            3'd5: return (32'(m_uce) << 12) | (32'(m_bto) << 11) | (32'(m_berr) << 10)
                       | (32'(m_hi) << 4) | 32'(m_afo);
            3'd6: return m_afar;
            default: return 32'd0;
        endcase
    endfunction

    function automatic string slot_tag(logic [2:0] s);
        case (s)
            3'd0: return "R2";
            3'd1, 3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            3'd5, 3'd6: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model update on every rising edge
    always @(posedge clk) begin
        logic [2:0] s;
        logic rd_f, rd_a;
        started = 1;
        cycles++;
        s = reg_addr[10:8];
        if (!rst_n) begin
            {m_sys, m_pso, m_nf, m_en} = '0; m_ctp = '0; m_ctx = '0;
            {m_ebe, m_lvl, m_at, m_ft, m_fav, m_ow, m_pend, m_trap} = '0; m_far = '0;
            {m_uce, m_bto, m_berr, m_afo, m_hi} = '0; m_afar = '0;
        end else begin
            rd_f = reg_rd_en && s == 3'd3;
            rd_a = reg_rd_en && s == 3'd5;
            m_trap = fault_valid && (!m_nf || fault_asi == 8'd9);
            if (reg_wr_en) begin
                if (s == 3'd0) begin
                    m_sys = reg_wdata[23:8]; m_pso = reg_wdata[7];
                    m_nf = reg_wdata[1]; m_en = reg_wdata[0];
                end
                if (s == 3'd1) m_ctp = reg_wdata & 32'hFFFF_FFFC;
                if (s == 3'd2) m_ctx = reg_wdata[7:0];
            end
            if (fault_valid) begin
                m_ow = (m_ow || m_pend) && !rd_f;
                m_ebe = fault_ebe; m_lvl = fault_level; m_at = fault_access;
                m_ft = fault_type; m_fav = fault_addr_valid; m_pend = 1;
                if (fault_addr_valid) m_far = fault_addr;
            end else if (rd_f) begin
                {m_ebe, m_lvl, m_at, m_ft, m_fav, m_ow, m_pend} = '0;
            end
            if (async_valid) begin
                m_uce = async_uce; m_bto = async_bto; m_berr = async_berr;
                m_hi = async_addr_hi; m_afo = 1; m_afar = async_addr;
            end else if (rd_a) begin
                {m_uce, m_bto, m_berr, m_afo, m_hi} = '0;
            end
        end
    end

    // Per-cycle comparison, away from both edges
    always @(negedge clk) begin
        #5;
        if (started) begin
            check("R9", 32'(trap), 32'(m_trap));
            check("R2", 32'(passthrough), 32'(!m_en));
            check("R2", 32'(pso), 32'(m_pso));
            check(slot_tag(reg_addr[10:8]), reg_rdata, m_read(reg_addr[10:8]));
        end
    end

    task automatic wr(logic [10:0] a, logic [31:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr_en = 1;
        @(negedge clk); reg_wr_en = 0;
    endtask

    task automatic rd(logic [10:0] a);
        @(negedge clk); reg_addr = a; reg_rd_en = 1;
        @(negedge clk); reg_rd_en = 0;
    endtask

    task automatic peek(string req, logic [10:0] a, logic [31:0] exp);
        @(negedge clk); reg_addr = a;
        #5 check(req, reg_rdata, exp);
    endtask

    task automatic flt(logic [1:0] l, logic [2:0] at, logic [2:0] ft, logic [7:0] e,
                       logic av, logic [31:0] ad, logic [7:0] asi, bit with_read);
        @(negedge clk);
        fault_valid = 1; fault_level = l; fault_access = at; fault_type = ft;
        fault_ebe = e; fault_addr_valid = av; fault_addr = ad; fault_asi = asi;
        if (with_read) begin reg_addr = 11'h300; reg_rd_en = 1; end
        @(negedge clk);
        fault_valid = 0; reg_rd_en = 0; fault_asi = '0;
    endtask

    task automatic trap_after(string req, logic [7:0] asi, logic exp);
        @(negedge clk);
        fault_valid = 1; fault_asi = asi; fault_type = 3'd2; fault_addr_valid = 0;
        @(negedge clk);
        fault_valid = 0; fault_asi = '0;
        #5 check(req, 32'(trap), 32'(exp));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset values
        peek("R1", 11'h000, {IMPL, VERS, 24'h0});
        peek("R1", 11'h300, 32'h0);
        #1 check("R1", 32'(passthrough), 32'd1);
        // R2: control fields and read-only IDs
        wr(11'h000, 32'hFFFF_FFFF);
        peek("R2", 11'h000, 32'h12FF_FF83);
        wr(11'h000, 32'h0000_0001);
        peek("R2", 11'h000, 32'h1200_0001);
        // R3: context base and context number
        wr(11'h100, 32'hDEAD_BEEF);
        peek("R3", 11'h100, 32'hDEAD_BEEC);
        wr(11'h2A0, 32'h0000_1234);
        peek("R3", 11'h200, 32'h0000_0034);
        // R4, R5: first fault
        flt(2'd2, 3'd5, 3'd2, 8'h81, 1, 32'hCAFE_0000, 8'd8, 0);
        peek("R4", 11'h300, fsr_val(8'h81, 2'd2, 3'd5, 3'd2, 1, 0));
        peek("R5", 11'h400, 32'hCAFE_0000);
        // R6: second fault unread, no valid address
        flt(2'd3, 3'd2, 3'd1, 8'h00, 0, 32'h1111_1111, 8'd8, 0);
        peek("R6", 11'h300, fsr_val(8'h00, 2'd3, 3'd2, 3'd1, 0, 1));
        peek("R5", 11'h400, 32'hCAFE_0000);
        flt(2'd1, 3'd7, 3'd4, 8'h00, 1, 32'h2222_0000, 8'd8, 0);
        peek("R6", 11'h300, fsr_val(8'h00, 2'd1, 3'd7, 3'd4, 1, 1));
        // R8: writes to fault slots ignored
        wr(11'h300, 32'hFFFF_FFFF);
        wr(11'h400, 32'h0);
        wr(11'h500, 32'hFFFF_FFFF);
        wr(11'h600, 32'hFFFF_FFFF);
        peek("R8", 11'h300, fsr_val(8'h00, 2'd1, 3'd7, 3'd4, 1, 1));
        peek("R8", 11'h400, 32'h2222_0000);
        peek("R8", 11'h500, 32'h0);
        peek("R8", 11'h600, 32'h0);
        // R7: read clears; fault with read keeps OW clear
        rd(11'h300);
        peek("R7", 11'h300, 32'h0);
        peek("R7", 11'h400, 32'h2222_0000);
        flt(2'd0, 3'd0, 3'd3, 8'h00, 0, 32'h0, 8'd8, 0);
        flt(2'd2, 3'd1, 3'd5, 8'h04, 0, 32'h0, 8'd8, 1);
        peek("R7", 11'h300, fsr_val(8'h04, 2'd2, 3'd1, 3'd5, 0, 0));
        rd(11'h300);
        // R9: traps with and without no-fault mode
        trap_after("R9", 8'd3, 1);
        wr(11'h000, 32'h0000_0003);
        trap_after("R9", 8'd3, 0);
        trap_after("R9", 8'd9, 1);
        trap_after("R9", 8'd10, 0);
        wr(11'h000, 32'h0000_0000);
        #1 check("R2", 32'(passthrough), 32'd1);
        rd(11'h300);
        // R10: asynchronous errors
        @(negedge clk);
        async_valid = 1; async_uce = 1; async_bto = 0; async_berr = 1;
        async_addr_hi = 4'hA; async_addr = 32'h8000_1000;
        @(negedge clk); async_valid = 0;
        peek("R10", 11'h500, 32'h0000_14A1);
        peek("R10", 11'h600, 32'h8000_1000);
        @(negedge clk);
        async_valid = 1; async_uce = 0; async_bto = 1; async_berr = 0;
        async_addr_hi = 4'h3; async_addr = 32'h0000_0040;
        @(negedge clk); async_valid = 0;
        peek("R10", 11'h500, 32'h0000_0831);
        rd(11'h500);
        peek("R10", 11'h500, 32'h0);
        peek("R10", 11'h600, 32'h0000_0040);
        // R11: unmapped slot
        peek("R11", 11'h700, 32'h0);
        peek("R11", 11'h7FF, 32'h0);
        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule